// File: doc/BRIEF.md
# Shared-Pin Bank Address Demultiplexer

This block sits between a processor and its memory. The processor puts the top byte of a 24-bit address (the bank byte) on its data pins during the first half of every bus cycle and uses the same pins for read or write data during the second half. The block makes the two bus phases from a clock that runs at twice the bus rate, captures the bank byte, and presents it with the sixteen address pins as one flat 24-bit address.

A two-state phase machine (states `PH_LOW` and `PH_HIGH`) changes state on every rising edge of the double-rate clock. Its transitions are `PH_LOW -> PH_HIGH` (the rise of `phi2`, which also loads the bank register) and `PH_HIGH -> PH_LOW` (the fall of `phi2`). The bank register follows the shared pins in the low phase and keeps the value that was on the pins at the rising edge. It drives its output at all times. The block also decodes the two address-qualifier inputs into a cycle kind. It raises an access strobe in the high phase of every cycle whose address is valid. Memory devices, wait states and data-direction control belong to other blocks.

Top module: `bank_addr_demux`

## Requirements
- R1: `phi2` toggles on every rising edge of `clk2x` after reset, so each phase lasts exactly one `clk2x` period.
- R2: `phi2_n` is always the exact complement of `phi2`.
- R3: While `rst_n` is low, `phi2` is 0, `phi2_n` is 1 and the bank byte (`full_addr[23:16]`) is 0.
- R4: The bank byte takes the value on `shared_bus` at the `clk2x` rising edge that drives `phi2` from 0 to 1. Values that appear earlier in the low phase have no effect.
- R5: The bank byte holds its value through the high phase and the low phase that follows, whatever `shared_bus` does, until the next rise of `phi2`.
- R6: `full_addr` is the bank byte in bits 23:16 and `cpu_addr` in bits 15:0.
- R7: `cyc_kind` is `{valid_prog, valid_data}`: 2'b11 opcode fetch, 2'b10 program operand, 2'b01 data access, 2'b00 internal cycle with no valid address.
- R8: `access_stb` is 1 exactly when `phi2` is 1 and `valid_data` or `valid_prog` is 1.
- R9: `valid_data` and `valid_prog` have no effect on which bank byte is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| shared_bus | input | 8 | Data pins: bank byte in the low phase, data in the high phase |
| cpu_addr | input | 16 | Lower sixteen address bits |
| valid_data | input | 1 | Address qualifier: data address |
| valid_prog | input | 1 | Address qualifier: program address |
| phi2 | output | 1 | Bus phase clock |
| phi2_n | output | 1 | Complement of `phi2` |
| full_addr | output | 24 | Bank byte and lower address combined |
| cyc_kind | output | 2 | Decoded cycle kind |
| access_stb | output | 1 | Valid memory access in the high phase |

## Verification
The bank byte is due one register stage after stimulus. A value placed on `shared_bus` in the middle of the low phase shows on `full_addr[23:16]` at the next `clk2x` rising edge, together with the rise of `phi2`. `cyc_kind`, `access_stb` and the lower address bits follow their inputs in the same cycle, and `access_stb` is gated by the registered phase. The driver changes inputs one nanosecond after a falling `clk2x` edge and queues the expected result. The monitor compares at the falling edge in the middle of the next high phase, after the loading edge. In the following low phase it checks that the bank byte is unchanged and that the strobe is low.

// File: rtl/bank_addr_demux_pkg.sv
package bank_addr_demux_pkg;

    // Phase state: a single flop whose true output is phi2
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    // Cycle kind, bit order {program qualifier, data qualifier}
    typedef enum logic [1:0] {
        CYC_INTERNAL = 2'b00,
        CYC_DATA     = 2'b01,
        CYC_OPERAND  = 2'b10,
        CYC_OPCODE   = 2'b11
    } cyc_kind_t;

endpackage

// File: rtl/bad_phase_gen.sv
module bad_phase_gen
    import bank_addr_demux_pkg::*;
(
    input  logic clk2x,
    input  logic rst_n,
    output logic phi2,
    output logic phi2_n,
    output logic load_bank
);

    phase_t state_q;
    phase_t state_d;

    // State register
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: PH_LOW -> PH_HIGH (rise), PH_HIGH -> PH_LOW (fall)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  state_d = PH_HIGH;
            PH_HIGH: state_d = PH_LOW;
        endcase
    end

    // Outputs: true and complement of the one state flop
    always_comb begin
        phi2      = 1'b0;
        phi2_n    = 1'b1;
        load_bank = 1'b0;
        unique case (state_q)
            PH_LOW: begin
                phi2      = 1'b0;
                phi2_n    = 1'b1;
                load_bank = 1'b1;
            end
            PH_HIGH: begin
                phi2      = 1'b1;
                phi2_n    = 1'b0;
                load_bank = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bank_hold.sv
module bank_hold #(
    parameter int BANK_W = 8
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              load_bank,
    input  logic [BANK_W-1:0] shared_bus,
    output logic [BANK_W-1:0] bank_q
);

    // Follows the pins in the low phase; the last load happens on the
    // edge that raises phi2, so the held value is the one at that edge.
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load_bank) begin
            bank_q <= shared_bus;
        end
    end

endmodule

// File: rtl/cycle_classify.sv
module cycle_classify
    import bank_addr_demux_pkg::*;
(
    input  logic      phi2,
    input  logic      valid_data,
    input  logic      valid_prog,
    output cyc_kind_t kind,
    output logic      access_stb
);

    always_comb begin
        kind = CYC_INTERNAL;
        unique case ({valid_prog, valid_data})
            2'b11: kind = CYC_OPCODE;
            2'b10: kind = CYC_OPERAND;
            2'b01: kind = CYC_DATA;
            2'b00: kind = CYC_INTERNAL;
        endcase
    end

    always_comb begin
        access_stb = phi2 && (kind != CYC_INTERNAL);
    end

endmodule

// File: rtl/bank_addr_demux.sv
module bank_addr_demux
    import bank_addr_demux_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int LOW_W  = 16,
    localparam int FULL_W = BANK_W + LOW_W
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] shared_bus,
    input  logic [LOW_W-1:0]  cpu_addr,
    input  logic              valid_data,
    input  logic              valid_prog,
    output logic              phi2,
    output logic              phi2_n,
    output logic [FULL_W-1:0] full_addr,
    output logic [1:0]        cyc_kind,
    output logic              access_stb
);

    logic              load_bank;
    logic [BANK_W-1:0] bank_q;
    cyc_kind_t         kind;

    bad_phase_gen u_phase (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .phi2      (phi2),
        .phi2_n    (phi2_n),
        .load_bank (load_bank)
    );

    bank_hold #(.BANK_W(BANK_W)) u_bank (
        .clk2x      (clk2x),
        .rst_n      (rst_n),
        .load_bank  (load_bank),
        .shared_bus (shared_bus),
        .bank_q     (bank_q)
    );

    cycle_classify u_class (
        .phi2       (phi2),
        .valid_data (valid_data),
        .valid_prog (valid_prog),
        .kind       (kind),
        .access_stb (access_stb)
    );

    assign full_addr = {bank_q, cpu_addr};
    assign cyc_kind  = kind;

endmodule

// File: rtl/bank_addr_demux_chk.sv
module bank_addr_demux_chk #(
    parameter int BANK_W = 8,
    parameter int LOW_W  = 16,
    localparam int FULL_W = BANK_W + LOW_W
) (
    input logic              clk2x,
    input logic              rst_n,
    input logic [BANK_W-1:0] shared_bus,
    input logic [LOW_W-1:0]  cpu_addr,
    input logic              valid_data,
    input logic              valid_prog,
    input logic              phi2,
    input logic              phi2_n,
    input logic [FULL_W-1:0] full_addr,
    input logic [1:0]        cyc_kind,
    input logic              access_stb
);

    // Set after the first edge out of reset so $past has a real history
    logic armed;
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_phase_toggle: assert property (@(posedge clk2x) disable iff (!rst_n)
        armed |-> (phi2 != $past(phi2)));

    a_r2_complement: assert property (@(posedge clk2x) disable iff (!rst_n)
        phi2_n == !phi2);

    always_comb begin
        if (!rst_n) begin
            a_r3_reset_state: assert (phi2 == 1'b0 && full_addr[FULL_W-1:LOW_W] == '0);
        end
    end

    a_r4_bank_load: assert property (@(posedge clk2x) disable iff (!rst_n)
        (armed && $rose(phi2)) |-> (full_addr[FULL_W-1:LOW_W] == $past(shared_bus)));

    a_r5_bank_hold: assert property (@(posedge clk2x) disable iff (!rst_n)
        (armed && !$rose(phi2)) |-> $stable(full_addr[FULL_W-1:LOW_W]));

    a_r6_low_bits: assert property (@(posedge clk2x) disable iff (!rst_n)
        full_addr[LOW_W-1:0] == cpu_addr);

    a_r7_kind: assert property (@(posedge clk2x) disable iff (!rst_n)
        cyc_kind == {valid_prog, valid_data});

    a_r8_strobe: assert property (@(posedge clk2x) disable iff (!rst_n)
        access_stb |-> (phi2 && (valid_data || valid_prog)));

endmodule

bind bank_addr_demux bank_addr_demux_chk #(.BANK_W(BANK_W), .LOW_W(LOW_W)) u_chk (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .shared_bus (shared_bus),
    .cpu_addr   (cpu_addr),
    .valid_data (valid_data),
    .valid_prog (valid_prog),
    .phi2       (phi2),
    .phi2_n     (phi2_n),
    .full_addr  (full_addr),
    .cyc_kind   (cyc_kind),
    .access_stb (access_stb)
);

// File: tb/sim_bank_addr_demux.sv
`timescale 1ns/1ps
module sim_bank_addr_demux;

    logic        clk2x = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  shared_bus = 8'h00;
    logic [15:0] cpu_addr = 16'h0000;
    logic        valid_data = 1'b0;
    logic        valid_prog = 1'b0;
    logic        phi2, phi2_n, access_stb;
    logic [23:0] full_addr;
    logic [1:0]  cyc_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0]  bank;
        logic [15:0] low;
        logic        vd;
        logic        vp;
    } exp_t;
    exp_t q[$];

    bank_addr_demux u0 (
        .clk2x(clk2x), .rst_n(rst_n), .shared_bus(shared_bus), .cpu_addr(cpu_addr),
        .valid_data(valid_data), .valid_prog(valid_prog), .phi2(phi2), .phi2_n(phi2_n),
        .full_addr(full_addr), .cyc_kind(cyc_kind), .access_stb(access_stb)
    );

    always #2 clk2x = ~clk2x;   // 250 MHz

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One bus cycle: garbage early, real bank mid low phase, data in high phase
    task automatic bus_cycle(input logic [7:0] garbage, input logic [7:0] bank,
                             input logic [15:0] low, input logic vd, input logic vp,
                             input logic [7:0] data);
        exp_t e;
        @(negedge clk2x);
        while (phi2 !== 1'b1) @(negedge clk2x);
        #1;
        shared_bus = garbage;
        cpu_addr   = low;
        valid_data = vd;
        valid_prog = vp;
        @(negedge clk2x);   // middle of low phase
        #1;
        shared_bus = bank;
        e.bank = bank; e.low = low; e.vd = vd; e.vp = vp;
        q.push_back(e);
        @(posedge clk2x);   // phi2 rises, bank loads
        #1;
        shared_bus = data;  // data on the pins must not disturb the bank
    endtask

    // Monitor: compare in the high phase, verify hold in the low phase
    logic [7:0] last_bank;
    bit         have_last = 0;
    logic       prev_phi2;
    bit         have_prev = 0;
    always @(negedge clk2x) begin
        if (rst_n && !done) begin
            check(phi2_n === ~phi2, "R2", "phi2_n complement", {31'b0, phi2_n}, {31'b0, ~phi2});
            if (have_prev)
                check(phi2 !== prev_phi2, "R1", "phase toggle", {31'b0, phi2}, {31'b0, ~prev_phi2});
            prev_phi2 = phi2;
            have_prev = 1;
            if (phi2 === 1'b1) begin
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(full_addr[23:16] === e.bank, "R4/R9", "bank byte",
                          {24'b0, full_addr[23:16]}, {24'b0, e.bank});
                    check(full_addr === {e.bank, e.low}, "R6", "full address",
                          {8'b0, full_addr}, {8'b0, e.bank, e.low});
                    check(cyc_kind === {e.vp, e.vd}, "R7", "cycle kind",
                          {30'b0, cyc_kind}, {30'b0, e.vp, e.vd});
                    check(access_stb === (e.vd | e.vp), "R8", "strobe high phase",
                          {31'b0, access_stb}, {31'b0, e.vd | e.vp});
                    last_bank = e.bank;
                    have_last = 1;
                end
            end else begin
                check(access_stb === 1'b0, "R8", "strobe low phase",
                      {31'b0, access_stb}, 32'b0);
                if (have_last)
                    check(full_addr[23:16] === last_bank, "R5", "bank held",
                          {24'b0, full_addr[23:16]}, {24'b0, last_bank});
            end
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        shared_bus = 8'hA5;
        repeat (3) @(posedge clk2x);
        @(negedge clk2x);
        check(phi2 === 1'b0, "R3", "phi2 in reset", {31'b0, phi2}, 32'b0);
        check(phi2_n === 1'b1, "R3", "phi2_n in reset", {31'b0, phi2_n}, 32'd1);
        check(full_addr[23:16] === 8'h00, "R3", "bank in reset",
              {24'b0, full_addr[23:16]}, 32'b0);
        rst_n = 1'b1;

        // R7 all four qualifier codes, R9 bank unaffected by qualifiers
        bus_cycle(8'hFF, 8'h12, 16'h3456, 1'b1, 1'b1, 8'hEE);
        bus_cycle(8'h12, 8'h7E, 16'hFFFC, 1'b0, 1'b1, 8'h00);
        bus_cycle(8'h00, 8'h01, 16'h0000, 1'b1, 1'b0, 8'hC3);
        bus_cycle(8'h55, 8'hAA, 16'h8000, 1'b0, 1'b0, 8'h3C);
        // Same bank repeated, boundary values
        bus_cycle(8'hAA, 8'hAA, 16'hFFFF, 1'b1, 1'b0, 8'hFF);
        bus_cycle(8'hFF, 8'h00, 16'h0001, 1'b0, 1'b1, 8'hFF);
        bus_cycle(8'h00, 8'hFF, 16'hABCD, 1'b1, 1'b1, 8'h00);
        for (int i = 0; i < 8; i++)
            bus_cycle(8'(i * 37), 8'(i * 29 + 3), 16'(i * 4099), 1'(i), 1'(i >> 1), 8'(~i));

        repeat (4) @(negedge clk2x);
        done = 1;
        summary();
    end

endmodule